// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a byte-wide flash memory model. A host drives it with processor-style active-low chip select, output enable and write strobes, an address bus and a data byte, plus a flag that shows whether the programming supply is present. The block turns those bus cycles into mode changes and into program and erase pulse requests for a behavioural array model that sits beside it. It also chooses what a read cycle returns: array contents, identifier codes, or the array location under verification.

Strobes are resynchronised to the system clock. A write takes effect when write enable rises while chip select is low. The address is sampled on the falling edge of write enable and the data on the rising edge. Program and erase pulses do not complete on their own. The host ends each pulse with the matching verify command. If the host waits too long, an internal stop timer ends the pulse and parks the controller in a halted state. Only the matching verify command or a reset sequence can move it out of that state.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the controller is in read mode, both pulse outputs are low, and a read returns the array byte at the live address.
- R2: dataOutEn is high only while ceN=0, oeN=0 and weN=1. With ceN high (standby) or oeN high (output disabled) it is low.
- R3: While vppHigh is 0, every command write is ignored and reads return array data. If vppHigh falls during a pulse, the pulse ends on the next clock and the controller goes to read mode.
- R4: Command 0x90 selects identifier mode. A read then returns 0x89 when address bit 0 is 0 and 0xB4 when it is 1, whatever the upper address bits are.
- R5: Command 0x40 followed by one further write starts a program pulse. progAddr and progData hold that second write's address and data, unchanged for as long as the pulse lasts. The program and erase pulses are never high together.
- R6: Command 0xC0 ends a program pulse. In program-verify mode arrayAddr presents the held program address, and reads return the array byte there.
- R7: Command 0x20 written twice in a row starts an erase pulse. If the second write is any other byte, the controller returns to read mode and no pulse starts.
- R8: Command 0xA0 ends an erase pulse and captures the address of its own write cycle. In erase-verify mode arrayAddr presents that address.
- R9: A program pulse that is not verified lasts exactly PROG_STOP_CYCLES clocks, and an erase pulse lasts exactly ERASE_STOP_CYCLES. After that the controller is halted. In the halted state, commands other than the matching verify or reset are ignored and reads return array data at the live address.
- R10: Two consecutive 0xFF writes return the controller to read mode from any state, ending any pulse. A single 0xFF followed by a different byte does not reset.
- R11: In read, identifier or verify modes, any byte that is not a defined command (0x00, 0x90, 0x20, 0xA0, 0x40, 0xC0, 0xFF) puts the controller in read mode.
- R12: A command takes effect only after write enable rises, never during the low phase. The held program address is the one present when write enable fell, even if the address bus changes before the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable |
| weN | input | 1 | Active-low write strobe |
| vppHigh | input | 1 | Programming supply present |
| addr | input | ADDR_W | Host address bus |
| dataIn | input | 8 | Host data byte (write direction) |
| dataOut | output | 8 | Read data toward the host |
| dataOutEn | output | 1 | Drive enable for the host data byte |
| arrayAddr | output | ADDR_W | Read address presented to the array model |
| arrayRdData | input | 8 | Array byte at arrayAddr |
| progPulse | output | 1 | Program pulse request |
| erasePulse | output | 1 | Erase pulse request |
| progAddr | output | ADDR_W | Held program/verify address |
| progData | output | 8 | Held program data |

## Verification
The command decoder is exercised with directed sequences for every defined command. Each sequence is ended in three different ways: by its verify command, by the stop timer, and by a double reset. This tells host-terminated pulses apart from timer-terminated ones by the measured pulse length. Random undefined bytes written from identifier mode check that only the listed codes are decoded. Random identifier reads with random upper address bits confirm that only bit 0 selects the code. Random program addresses and data confirm the holding registers. A write whose address changes while write enable is low separates falling-edge address capture from rising-edge capture. Repeating sequences with the supply flag low shows that every write is ignored.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    MODE_READ,
    MODE_IDENT,
    MODE_ERASE_SETUP,
    MODE_ERASING,
    MODE_ERASE_HALT,
    MODE_ERASE_VERIFY,
    MODE_PROG_SETUP,
    MODE_PROGRAMMING,
    MODE_PROG_HALT,
    MODE_PROG_VERIFY
  } flashMode_e;

  localparam logic [7:0] CMD_READ      = 8'h00;
  localparam logic [7:0] CMD_IDENT     = 8'h90;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_ERASE_VFY = 8'hA0;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_PROG_VFY  = 8'hC0;
  localparam logic [7:0] CMD_RESET     = 8'hFF;

  localparam logic [7:0] MAKER_CODE = 8'h89;
  localparam logic [7:0] PART_CODE  = 8'hB4;

  // Strobes from control to datapath
  typedef struct packed {
    logic       stageAddr;  // sample address bus (write enable fell)
    logic       holdAddr;   // move staged address into holding register
    logic       holdData;   // capture data byte into holding register
    flashMode_e mode;       // current operating mode
  } ctrlStrobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int SYNC_STAGES       = 2,
  parameter int PROG_STOP_CYCLES  = 2000,
  parameter int ERASE_STOP_CYCLES = 2000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        vppHigh,
  input  logic [7:0]  cmdByte,
  output ctrlStrobe_t strobe
);

  localparam int MAX_STOP = (PROG_STOP_CYCLES > ERASE_STOP_CYCLES) ?
                            PROG_STOP_CYCLES : ERASE_STOP_CYCLES;
  localparam int CNT_W = $clog2(MAX_STOP + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_STOP_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_STOP_CYCLES - 1);

  logic [SYNC_STAGES-1:0] weSync, ceSync;
  logic                   wePrev;
  logic                   weNow, ceNow, weFall, weRise, cmdWrite;

  flashMode_e       mode, modeNext;
  logic             resetArm, resetArmNext;
  logic [CNT_W-1:0] timer;
  logic             timerLoad;
  logic [CNT_W-1:0] loadVal;
  logic             holdAddrStb, holdDataStb;
  logic             pulsing, pulsingNext;

  // Strobe resynchronisation and edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      weSync <= '1;
      ceSync <= '1;
      wePrev <= 1'b1;
    end else begin
      weSync <= {weSync[SYNC_STAGES-2:0], weN};
      ceSync <= {ceSync[SYNC_STAGES-2:0], ceN};
      wePrev <= weNow;
    end
  end

  assign weNow    = weSync[SYNC_STAGES-1];
  assign ceNow    = ceSync[SYNC_STAGES-1];
  assign weFall   = wePrev && !weNow && !ceNow;
  assign weRise   = !wePrev && weNow && !ceNow;
  assign cmdWrite = weRise && vppHigh;

  assign pulsing     = (mode == MODE_PROGRAMMING) || (mode == MODE_ERASING);
  assign pulsingNext = (modeNext == MODE_PROGRAMMING) || (modeNext == MODE_ERASING);

  always_comb begin
    modeNext     = mode;
    resetArmNext = resetArm;
    timerLoad    = 1'b0;
    loadVal      = '0;
    holdAddrStb  = 1'b0;
    holdDataStb  = 1'b0;
    if (!vppHigh) begin
      modeNext     = MODE_READ;
      resetArmNext = 1'b0;
    end else if (cmdWrite) begin
      resetArmNext = (cmdByte == CMD_RESET) && !resetArm;
      if (mode == MODE_PROG_SETUP) begin
        modeNext     = MODE_PROGRAMMING;
        resetArmNext = 1'b0;
        holdAddrStb  = 1'b1;
        holdDataStb  = 1'b1;
        timerLoad    = 1'b1;
        loadVal      = PROG_LOAD;
      end else if (cmdByte == CMD_RESET) begin
        if (resetArm) modeNext = MODE_READ;
      end else begin
        unique case (mode)
          MODE_ERASE_SETUP: begin
            if (cmdByte == CMD_ERASE) begin
              modeNext  = MODE_ERASING;
              timerLoad = 1'b1;
              loadVal   = ERASE_LOAD;
            end else begin
              modeNext = MODE_READ;
            end
          end
          MODE_PROGRAMMING, MODE_PROG_HALT: begin
            if (cmdByte == CMD_PROG_VFY) modeNext = MODE_PROG_VERIFY;
          end
          MODE_ERASING, MODE_ERASE_HALT: begin
            if (cmdByte == CMD_ERASE_VFY) begin
              modeNext    = MODE_ERASE_VERIFY;
              holdAddrStb = 1'b1;
            end
          end
          default: begin
            unique case (cmdByte)
              CMD_IDENT:     modeNext = MODE_IDENT;
              CMD_ERASE:     modeNext = MODE_ERASE_SETUP;
              CMD_PROG:      modeNext = MODE_PROG_SETUP;
              CMD_PROG_VFY:  modeNext = MODE_PROG_VERIFY;
              CMD_ERASE_VFY: begin
                modeNext    = MODE_ERASE_VERIFY;
                holdAddrStb = 1'b1;
              end
              default:       modeNext = MODE_READ;
            endcase
          end
        endcase
      end
    end
    // Stop timer ends a pulse that no command has ended
    if (pulsing && (modeNext == mode) && (timer == '0)) begin
      modeNext = (mode == MODE_PROGRAMMING) ? MODE_PROG_HALT : MODE_ERASE_HALT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_READ;
      resetArm <= 1'b0;
      timer    <= '0;
    end else begin
      mode     <= modeNext;
      resetArm <= resetArmNext;
      if (timerLoad)         timer <= loadVal;
      else if (!pulsingNext) timer <= '0;
      else if (timer != '0)  timer <= timer - 1'b1;
    end
  end

  assign strobe.stageAddr = weFall && vppHigh;
  assign strobe.holdAddr  = holdAddrStb;
  assign strobe.holdData  = holdDataStb;
  assign strobe.mode      = mode;

endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic [7:0]        arrayRdData,
  output logic [ADDR_W-1:0] arrayAddr,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic [7:0]        dataOut
);

  logic [ADDR_W-1:0] addrStage;
  logic              verifyMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrStage <= '0;
      progAddr  <= '0;
      progData  <= '0;
    end else begin
      if (strobe.stageAddr) addrStage <= addr;
      if (strobe.holdAddr)  progAddr  <= addrStage;
      if (strobe.holdData)  progData  <= dataIn;
    end
  end

  assign verifyMode = (strobe.mode == MODE_PROG_VERIFY) ||
                      (strobe.mode == MODE_ERASE_VERIFY);
  assign arrayAddr  = verifyMode ? progAddr : addr;

  always_comb begin
    if (strobe.mode == MODE_IDENT) dataOut = addr[0] ? PART_CODE : MAKER_CODE;
    else                           dataOut = arrayRdData;
  end

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W            = 17,
  parameter int SYNC_STAGES       = 2,
  parameter int PROG_STOP_CYCLES  = 2000,
  parameter int ERASE_STOP_CYCLES = 2000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              vppHigh,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn,
  output logic [ADDR_W-1:0] arrayAddr,
  input  logic [7:0]        arrayRdData,
  output logic              progPulse,
  output logic              erasePulse,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData
);

  ctrlStrobe_t strobe;

  flash_cmd_ctrl #(
    .SYNC_STAGES      (SYNC_STAGES),
    .PROG_STOP_CYCLES (PROG_STOP_CYCLES),
    .ERASE_STOP_CYCLES(ERASE_STOP_CYCLES)
  ) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .ceN    (ceN),
    .weN    (weN),
    .vppHigh(vppHigh),
    .cmdByte(dataIn),
    .strobe (strobe)
  );

  flash_cmd_datapath #(
    .ADDR_W(ADDR_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .addr       (addr),
    .dataIn     (dataIn),
    .arrayRdData(arrayRdData),
    .arrayAddr  (arrayAddr),
    .progAddr   (progAddr),
    .progData   (progData),
    .dataOut    (dataOut)
  );

  assign dataOutEn  = !ceN && !oeN && weN;
  assign progPulse  = (strobe.mode == MODE_PROGRAMMING);
  assign erasePulse = (strobe.mode == MODE_ERASING);

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
  parameter int ADDR_W            = 17,
  parameter int PROG_STOP_CYCLES  = 2000,
  parameter int ERASE_STOP_CYCLES = 2000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              vppHigh,
  input logic              progPulse,
  input logic              erasePulse,
  input logic [ADDR_W-1:0] progAddr,
  input logic [7:0]        progData
);

  logic [31:0] progRun, eraseRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progRun  <= '0;
      eraseRun <= '0;
    end else begin
      progRun  <= progPulse  ? progRun + 1'b1  : '0;
      eraseRun <= erasePulse ? eraseRun + 1'b1 : '0;
    end
  end

  AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(progPulse && erasePulse)); // R5

  AST_NO_SUPPLY_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !vppHigh |=> (!progPulse && !erasePulse)); // R3

  AST_PROG_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (progPulse && $past(progPulse)) |-> ($stable(progAddr) && $stable(progData))); // R5

  AST_PROG_STOP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |-> (progRun < PROG_STOP_CYCLES)); // R9

  AST_ERASE_STOP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    erasePulse |-> (eraseRun < ERASE_STOP_CYCLES)); // R9

endmodule

bind flash_cmd_if flash_cmd_if_chk #(
  .ADDR_W           (ADDR_W),
  .PROG_STOP_CYCLES (PROG_STOP_CYCLES),
  .ERASE_STOP_CYCLES(ERASE_STOP_CYCLES)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .vppHigh   (vppHigh),
  .progPulse (progPulse),
  .erasePulse(erasePulse),
  .progAddr  (progAddr),
  .progData  (progData)
);

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int AW = 8;
  localparam int PL = 120;
  localparam int EL = 200;

  logic          clk = 1'b0;
  logic          rstN, ceN, oeN, weN, vppHigh;
  logic [AW-1:0] addr;
  logic [7:0]    dataIn, dataOut, arrayRdData, progData;
  logic          dataOutEn, progPulse, erasePulse;
  logic [AW-1:0] arrayAddr, progAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int progCnt = 0, progLast = 0, eraseCnt = 0, eraseLast = 0;

  always #2.5 clk = ~clk;

  flash_cmd_if #(
    .ADDR_W(AW), .SYNC_STAGES(2),
    .PROG_STOP_CYCLES(PL), .ERASE_STOP_CYCLES(EL)
  ) i_flash_cmd_if (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .vppHigh(vppHigh), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .arrayAddr(arrayAddr), .arrayRdData(arrayRdData),
    .progPulse(progPulse), .erasePulse(erasePulse),
    .progAddr(progAddr), .progData(progData)
  );

  function automatic logic [7:0] arrayFn(input logic [AW-1:0] a);
    return (a * 8'd29) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] identFn(input logic [AW-1:0] a);
    return a[0] ? 8'hB4 : 8'h89;
  endfunction

  assign arrayRdData = arrayFn(arrayAddr);

  // Pulse length monitor
  always @(negedge clk) begin
    if (progPulse) progCnt <= progCnt + 1;
    else if (progCnt != 0) begin progLast <= progCnt; progCnt <= 0; end
    if (erasePulse) eraseCnt <= eraseCnt + 1;
    else if (eraseCnt != 0) begin eraseLast <= eraseCnt; eraseCnt <= 0; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; ceN = 1'b0; weN = 1'b0;
    repeat (4) @(negedge clk);
    dataIn = d; weN = 1'b1;
    repeat (5) @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk);
    q = dataOut;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic readChk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] q;
    busRead(a, q);
    chk(req, q, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    logic [AW-1:0] ra, rb;
    logic [7:0] rd;
    void'($urandom(32'd4242));
    rstN = 1'b0; ceN = 1'b1; oeN = 1'b1; weN = 1'b1; vppHigh = 1'b1;
    addr = '0; dataIn = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 progPulse", progPulse, 0);
    chk("R1 erasePulse", erasePulse, 0);
    chk("R2 standby dataOutEn", dataOutEn, 0);
    readChk("R1 read", 8'h33, arrayFn(8'h33));

    // R2 output enable gating
    @(negedge clk); addr = 8'h10; ceN = 1'b1; oeN = 1'b0;
    @(negedge clk); chk("R2 ce high", dataOutEn, 0);
    ceN = 1'b0; oeN = 1'b1;
    @(negedge clk); chk("R2 oe high", dataOutEn, 0);
    oeN = 1'b0;
    @(negedge clk); chk("R2 read enable", dataOutEn, 1);
    ceN = 1'b1; oeN = 1'b1;

    // R4 identifier
    busWrite(8'h00, 8'h90);
    readChk("R4 maker", 8'h00, 8'h89);
    readChk("R4 device", 8'h01, 8'hB4);
    for (int i = 0; i < 12; i++) begin
      ra = AW'($urandom);
      readChk("R4 random ident", ra, identFn(ra));
    end

    // R11 undefined commands from ident mode
    for (int i = 0; i < 10; i++) begin
      busWrite(8'h00, 8'h90);
      rd = 8'($urandom);
      if (rd == 8'h00 || rd == 8'h90 || rd == 8'h20 || rd == 8'hA0 ||
          rd == 8'h40 || rd == 8'hC0 || rd == 8'hFF) rd = 8'h55;
      busWrite(8'h00, rd);
      ra = AW'($urandom);
      readChk("R11 undefined to read", ra, arrayFn(ra));
    end

    // R3 supply absent: commands ignored
    vppHigh = 1'b0;
    busWrite(8'h00, 8'h90);
    readChk("R3 ignore ident", 8'h00, arrayFn(8'h00));
    busWrite(8'h00, 8'h40);
    busWrite(8'h21, 8'h77);
    chk("R3 no program", progPulse, 0);
    vppHigh = 1'b1;

    // R5/R6 program then verify, random address/data
    for (int i = 0; i < 6; i++) begin
      ra = AW'($urandom); rd = 8'($urandom);
      busWrite(8'h00, 8'h40);
      busWrite(ra, rd);
      chk("R5 program pulse", progPulse, 1);
      chk("R5 progAddr", progAddr, ra);
      chk("R5 progData", progData, rd);
      busWrite(8'h00, 8'hC0);
      chk("R6 verify ends pulse", progPulse, 0);
      chk("R6 verify arrayAddr", arrayAddr, ra);
      readChk("R6 verify read", 8'h00, arrayFn(ra));
      chk("R6 length below limit", (progLast < PL), 1);
    end
    busWrite(8'h00, 8'h00);

    // R12 address captured at falling edge, effect at rising edge
    busWrite(8'h00, 8'h40);
    @(negedge clk);
    addr = 8'h3C; ceN = 1'b0; weN = 1'b0;
    repeat (4) @(negedge clk);
    addr = 8'hC3;
    repeat (2) @(negedge clk);
    chk("R12 no effect while low", progPulse, 0);
    dataIn = 8'h5E; weN = 1'b1;
    repeat (5) @(negedge clk);
    ceN = 1'b1;
    @(negedge clk);
    chk("R12 pulse after rise", progPulse, 1);
    chk("R12 falling-edge address", progAddr, 8'h3C);

    // R3 supply drop ends the pulse
    vppHigh = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R3 drop ends pulse", progPulse, 0);
    vppHigh = 1'b1;
    readChk("R3 read after drop", 8'h01, arrayFn(8'h01));

    // R9 program stop timer and halted state
    busWrite(8'h00, 8'h40);
    busWrite(8'h44, 8'h12);
    repeat (PL + 20) @(negedge clk);
    chk("R9 program halted", progPulse, 0);
    chk("R9 program length", progLast, PL);
    busWrite(8'h00, 8'h90);
    readChk("R9 halt ignores ident", 8'h00, arrayFn(8'h00));
    chk("R9 halt no restart", progPulse, 0);
    busWrite(8'h00, 8'hC0);
    chk("R9 verify leaves halt", arrayAddr, 8'h44);

    // R7 erase and erase verify (R8)
    busWrite(8'h00, 8'h20);
    busWrite(8'h00, 8'h20);
    chk("R7 erase pulse", erasePulse, 1);
    busWrite(8'h9A, 8'hA0);
    chk("R8 verify ends erase", erasePulse, 0);
    chk("R8 verify address", arrayAddr, 8'h9A);
    readChk("R8 verify read", 8'h00, arrayFn(8'h9A));

    // R7 erase aborted by a wrong confirm byte
    busWrite(8'h00, 8'h20);
    busWrite(8'h00, 8'h55);
    chk("R7 abort no pulse", erasePulse, 0);
    readChk("R7 abort read mode", 8'h00, arrayFn(8'h00));

    // R9 erase stop timer, then R10 reset out of halt
    busWrite(8'h00, 8'h20);
    busWrite(8'h00, 8'h20);
    repeat (EL + 20) @(negedge clk);
    chk("R9 erase halted", erasePulse, 0);
    chk("R9 erase length", eraseLast, EL);
    busWrite(8'h00, 8'hFF);
    busWrite(8'h00, 8'hFF);
    busWrite(8'h00, 8'h90);
    readChk("R10 reset from halt", 8'h01, 8'hB4);

    // R10 a single 0xFF then another byte is not a reset
    busWrite(8'h00, 8'h40);
    busWrite(8'h07, 8'hE1);
    busWrite(8'h00, 8'hFF);
    busWrite(8'h00, 8'h90);
    busWrite(8'h00, 8'hFF);
    chk("R10 broken pair keeps pulse", progPulse, 1);
    busWrite(8'h00, 8'hFF);
    chk("R10 pair ends pulse", progPulse, 0);
    rb = 8'h5D;
    readChk("R10 read mode", rb, arrayFn(rb));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule